// File: doc/BRIEF.md
# IO Bank Freeze Sequencer

This block parks the pad controls of general-purpose IO banks in a safe frozen condition and brings them back out. Each bank slot has its own request. A request carries one direction bit that asks for freeze or thaw. The sequencer then walks the five pad controls of that bank through a fixed ordering. Between consecutive steps it holds a minimum gap, counted in clock cycles. The five controls are slew enable, weak pull-up, tristate and bus-hold, which are all active low, and configuration-done, which is active high.

Freezing takes two steps. Thawing takes three steps and releases the controls in the reverse order. While a sequence runs, the bank reports busy. When the final step lands, it raises done for one cycle and updates its frozen flag. A single instance covers `NUM_BANKS` independent slots. The minimum gap is given in nanoseconds and is converted against the clock period at elaboration.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset every bank is frozen: `slew_n`, `wkpu_n`, `trist_n`, `bhold_n` and `cfgdone` all read 0, `frozen` reads 1, and `busy` and `done` read 0.
- R2: A freeze request (`req_valid`=1, `req_freeze`=1) accepted on a thawed bank drives `slew_n`, `wkpu_n` and `trist_n` to 0 together, one cycle after the sampling edge. The same edge raises `busy`, and `bhold_n` and `cfgdone` stay at 1.
- R3: GAP cycles after the first freeze step, `bhold_n` and `cfgdone` fall together and `frozen` becomes 1.
- R4: A thaw request (`req_valid`=1, `req_freeze`=0) accepted on a frozen bank raises `bhold_n` and `cfgdone` together, with the other three controls still at 0.
- R5: GAP cycles after the first thaw step, `wkpu_n` and `trist_n` rise together.
- R6: GAP cycles after that, `slew_n` rises last and `frozen` becomes 0.
- R7: GAP equals the minimum gap in ns times 1000, divided by the clock period in ps and rounded up, with a floor of 1 cycle. Every step gap lasts at least GAP cycles.
- R8: `busy` stays high from acceptance until the last step. `done` is high for exactly the cycle in which the last step appears, and `busy` is low whenever `done` is high. Requests that arrive while `busy` is high are ignored and do not change the running sequence.
- R9: A request for the state the bank is already in raises `done` for one cycle. `busy` stays low and no pad control changes.
- R10: Each bank slot sequences independently on its own request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_BANKS | Per-bank request strobe |
| req_freeze | input | NUM_BANKS | Requested direction: 1 freeze, 0 thaw |
| slew_n | output | NUM_BANKS | Slew-enable control, active low |
| wkpu_n | output | NUM_BANKS | Weak pull-up control, active low |
| trist_n | output | NUM_BANKS | Tristate control, active low |
| bhold_n | output | NUM_BANKS | Bus-hold control, active low |
| cfgdone | output | NUM_BANKS | Configuration-done control, active high |
| frozen | output | NUM_BANKS | Bank status: 1 frozen, 0 thawed |
| busy | output | NUM_BANKS | Sequence in progress |
| done | output | NUM_BANKS | One-cycle completion pulse |

## Verification
The bench builds the block with three bank slots, a 4000 ps clock period and a 22 ns minimum gap. With these values the gap does not divide evenly, so it must round up to 6 cycles. This exposes any truncation in the gap conversion and makes the per-step timing visible at a resolution coarser than a single cycle. Using three slots lets simultaneous freeze and thaw sequences in different banks run side by side. It also lets the bench show that a request to one bank leaves the others untouched.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;

   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_FRZ_WAIT = 2'd1,
      PH_THW_WAIT = 2'd2,
      PH_THW_LAST = 2'd3
   } iofrz_phase_e;

   typedef struct packed {
      logic slew_n;
      logic wkpu_n;
      logic trist_n;
      logic bhold_n;
      logic cfgdone;
   } pad_ctrl_t;

   localparam pad_ctrl_t PAD_FROZEN = '{slew_n: 1'b0, wkpu_n: 1'b0, trist_n: 1'b0,
                                        bhold_n: 1'b0, cfgdone: 1'b0};

   // Cycles covering a minimum gap in ns, rounded up, never below one.
   function automatic int gap_cycles(input int gap_ns, input int clk_ps);
      int c;
      c = (gap_ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/iofrz_gap_timer.sv
module iofrz_gap_timer #(
   parameter int GAP_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

   initial begin
      if (GAP_CYC < 1) $error("iofrz_gap_timer: GAP_CYC must be at least 1");
   end

   logic running;

   generate
      if (GAP_CYC == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) running <= 1'b0;
            else        running <= start;
         end
         assign expired = running;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               running <= 1'b0;
               cnt     <= '0;
            end else if (start) begin
               running <= 1'b1;
               cnt     <= CNT_W'(GAP_CYC - 1);
            end else if (running) begin
               if (cnt == '0) running <= 1'b0;
               else           cnt     <= cnt - 1'b1;
            end
         end
         assign expired = running && (cnt == '0);
      end
   endgenerate

   AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!running || expired)); // R8

endmodule

// File: rtl/iofrz_bank_seq.sv
module iofrz_bank_seq
   import iofrz_pkg::*;
#(
   parameter int GAP_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_freeze,
   output logic slew_n,
   output logic wkpu_n,
   output logic trist_n,
   output logic bhold_n,
   output logic cfgdone,
   output logic frozen,
   output logic busy,
   output logic done
);
   iofrz_phase_e phase_q, phase_d;
   pad_ctrl_t    pad_q, pad_d;
   logic         frz_q, frz_d;
   logic         busy_q, busy_d;
   logic         done_q, done_d;
   logic         tmr_start, tmr_exp;

   iofrz_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .expired (tmr_exp)
   );

   always_comb begin
      phase_d   = phase_q;
      pad_d     = pad_q;
      frz_d     = frz_q;
      busy_d    = busy_q;
      done_d    = 1'b0;
      tmr_start = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               if (req_freeze == frz_q) begin
                  done_d = 1'b1;
               end else if (req_freeze) begin
                  pad_d.slew_n  = 1'b0;
                  pad_d.wkpu_n  = 1'b0;
                  pad_d.trist_n = 1'b0;
                  busy_d        = 1'b1;
                  tmr_start     = 1'b1;
                  phase_d       = PH_FRZ_WAIT;
               end else begin
                  pad_d.bhold_n = 1'b1;
                  pad_d.cfgdone = 1'b1;
                  busy_d        = 1'b1;
                  tmr_start     = 1'b1;
                  phase_d       = PH_THW_WAIT;
               end
            end
         end
         PH_FRZ_WAIT: begin
            if (tmr_exp) begin
               pad_d.bhold_n = 1'b0;
               pad_d.cfgdone = 1'b0;
               frz_d         = 1'b1;
               busy_d        = 1'b0;
               done_d        = 1'b1;
               phase_d       = PH_IDLE;
            end
         end
         PH_THW_WAIT: begin
            if (tmr_exp) begin
               pad_d.wkpu_n  = 1'b1;
               pad_d.trist_n = 1'b1;
               tmr_start     = 1'b1;
               phase_d       = PH_THW_LAST;
            end
         end
         PH_THW_LAST: begin
            if (tmr_exp) begin
               pad_d.slew_n = 1'b1;
               frz_d        = 1'b0;
               busy_d       = 1'b0;
               done_d       = 1'b1;
               phase_d      = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pad_q   <= PAD_FROZEN;
         frz_q   <= 1'b1;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         pad_q   <= pad_d;
         frz_q   <= frz_d;
         busy_q  <= busy_d;
         done_q  <= done_d;
      end
   end

   assign slew_n  = pad_q.slew_n;
   assign wkpu_n  = pad_q.wkpu_n;
   assign trist_n = pad_q.trist_n;
   assign bhold_n = pad_q.bhold_n;
   assign cfgdone = pad_q.cfgdone;
   assign frozen  = frz_q;
   assign busy    = busy_q;
   assign done    = done_q;

   // Quiet-time counter: cycles since the pad controls last changed.
   localparam int QW = $clog2(GAP_CYC + 1) + 1;
   logic [QW-1:0] quiet;
   pad_ctrl_t     pad_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet    <= '1;
         pad_prev <= PAD_FROZEN;
      end else begin
         pad_prev <= pad_q;
         if (pad_q != pad_prev)  quiet <= '0;
         else if (quiet != '1)   quiet <= quiet + 1'b1;
      end
   end

   AST_FRZ_HOLD_AFTER_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bhold_n) |-> (!slew_n && !wkpu_n && !trist_n && !cfgdone && frozen)); // R3
   AST_THW_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wkpu_n) |-> (trist_n && bhold_n && cfgdone && !slew_n)); // R5
   AST_THW_SLEW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slew_n) |-> (wkpu_n && trist_n && bhold_n && cfgdone && !frozen)); // R6
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bhold_n) || $rose(wkpu_n) || $rose(slew_n)) |-> (int'(quiet) >= GAP_CYC - 1)); // R7
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
   AST_IDLE_PADS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(pad_q) && $stable(frozen))); // R9

endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq #(
   parameter int NUM_BANKS     = 3,
   parameter int CLK_PERIOD_PS = 4000,
   parameter int MIN_GAP_NS    = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] req_valid,
   input  logic [NUM_BANKS-1:0] req_freeze,
   output logic [NUM_BANKS-1:0] slew_n,
   output logic [NUM_BANKS-1:0] wkpu_n,
   output logic [NUM_BANKS-1:0] trist_n,
   output logic [NUM_BANKS-1:0] bhold_n,
   output logic [NUM_BANKS-1:0] cfgdone,
   output logic [NUM_BANKS-1:0] frozen,
   output logic [NUM_BANKS-1:0] busy,
   output logic [NUM_BANKS-1:0] done
);
   localparam int GAP_CYC = iofrz_pkg::gap_cycles(MIN_GAP_NS, CLK_PERIOD_PS);

   initial begin
      if (NUM_BANKS < 1)     $error("io_freeze_seq: NUM_BANKS must be at least 1");
      if (CLK_PERIOD_PS < 1) $error("io_freeze_seq: CLK_PERIOD_PS must be positive");
      if (MIN_GAP_NS < 0)    $error("io_freeze_seq: MIN_GAP_NS must not be negative");
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         iofrz_bank_seq #(.GAP_CYC(GAP_CYC)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[b]),
            .req_freeze (req_freeze[b]),
            .slew_n     (slew_n[b]),
            .wkpu_n     (wkpu_n[b]),
            .trist_n    (trist_n[b]),
            .bhold_n    (bhold_n[b]),
            .cfgdone    (cfgdone[b]),
            .frozen     (frozen[b]),
            .busy       (busy[b]),
            .done       (done[b])
         );
      end
   endgenerate

endmodule

// File: tb/io_freeze_seq_bench.sv
`timescale 1ns/1ps
module io_freeze_seq_bench;
   localparam int NB     = 3;
   localparam int CLK_PS = 4000;
   localparam int GAP_NS = 22;
   localparam int G      = ((GAP_NS * 1000 + CLK_PS - 1) / CLK_PS < 1) ? 1
                         : (GAP_NS * 1000 + CLK_PS - 1) / CLK_PS;   // R7: 6

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NB-1:0] req_valid = '0, req_freeze = '0;
   logic [NB-1:0] slew_n, wkpu_n, trist_n, bhold_n, cfgdone, frozen, busy, done;

   always #2 clk = ~clk;

   io_freeze_seq #(.NUM_BANKS(NB), .CLK_PERIOD_PS(CLK_PS), .MIN_GAP_NS(GAP_NS)) u_io_freeze_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freeze(req_freeze),
      .slew_n(slew_n), .wkpu_n(wkpu_n), .trist_n(trist_n), .bhold_n(bhold_n),
      .cfgdone(cfgdone), .frozen(frozen), .busy(busy), .done(done));

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // Behavioural reference: per-bank step number and remaining wait.
   int ph [NB];
   int wt [NB];
   logic [NB-1:0] m_sl, m_wk, m_tr, m_bh, m_cd, m_fz, m_bz, m_dn;
   logic [NB-1:0] smp_busy, smp_done, smp_frz, smp_sl, smp_bh, smp_wk;

   task automatic check(input logic act, input logic exp, input string tag, input int b);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s bank %0d: actual %0b expected %0b at %0t", tag, b, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin ph[b] = 0; wt[b] = 0; end
      m_sl = '0; m_wk = '0; m_tr = '0; m_bh = '0; m_cd = '0;
      m_fz = '1; m_bz = '0; m_dn = '0;
   endtask

   task automatic model_step(input logic [NB-1:0] v, input logic [NB-1:0] f);
      for (int b = 0; b < NB; b++) begin
         m_dn[b] = 1'b0;
         if (ph[b] == 0) begin
            if (v[b]) begin
               if (f[b] == m_fz[b]) m_dn[b] = 1'b1;                    // R9
               else if (f[b]) begin
                  m_sl[b] = 0; m_wk[b] = 0; m_tr[b] = 0; m_bz[b] = 1; ph[b] = 1; wt[b] = G;
               end else begin
                  m_bh[b] = 1; m_cd[b] = 1; m_bz[b] = 1; ph[b] = 2; wt[b] = G;
               end
            end
         end else begin
            wt[b]--;
            if (wt[b] == 0) begin
               if (ph[b] == 1) begin
                  m_bh[b] = 0; m_cd[b] = 0; m_fz[b] = 1; m_bz[b] = 0; m_dn[b] = 1; ph[b] = 0;
               end else if (ph[b] == 2) begin
                  m_wk[b] = 1; m_tr[b] = 1; ph[b] = 3; wt[b] = G;
               end else begin
                  m_sl[b] = 1; m_fz[b] = 0; m_bz[b] = 0; m_dn[b] = 1; ph[b] = 0;
               end
            end
         end
      end
   endtask

   task automatic compare_all();
      for (int b = 0; b < NB; b++) begin
         check(slew_n[b],  m_sl[b], "R2/R6 slew_n", b);
         check(wkpu_n[b],  m_wk[b], "R2/R5 wkpu_n", b);
         check(trist_n[b], m_tr[b], "R2/R5 trist_n", b);
         check(bhold_n[b], m_bh[b], "R3/R4 bhold_n", b);
         check(cfgdone[b], m_cd[b], "R3/R4 cfgdone", b);
         check(frozen[b],  m_fz[b], "R3/R6 frozen", b);
         check(busy[b],    m_bz[b], "R8 busy", b);
         check(done[b],    m_dn[b], "R8/R9 done", b);
      end
      smp_busy = busy; smp_done = done; smp_frz = frozen;
      smp_sl = slew_n; smp_bh = bhold_n; smp_wk = wkpu_n;
   endtask

   // One clock: compare at the falling edge, drive, advance the model.
   task automatic cyc(input logic [NB-1:0] v, input logic [NB-1:0] f);
      @(negedge clk);
      compare_all();
      req_valid = v; req_freeze = f;
      model_step(v, f);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset values
      for (int b = 0; b < NB; b++) begin
         check(slew_n[b] | wkpu_n[b] | trist_n[b] | bhold_n[b] | cfgdone[b], 1'b0, "R1 pads", b);
         check(frozen[b], 1'b1, "R1 frozen", b);
         check(busy[b] | done[b], 1'b0, "R1 busy/done", b);
      end
      rst_n = 1'b1;
      cyc('0, '0);
      cyc('0, '0);

      // R4/R5/R6: thaw bank 0; R9: freeze already-frozen bank 1
      cyc(3'b011, 3'b010);
      cyc('0, '0);
      check(smp_done[1], 1'b1, "R9 done on same-state", 1);
      check(smp_busy[1], 1'b0, "R9 busy stays low", 1);
      check(smp_bh[0], 1'b1, "R4 bus-hold released first", 0);
      check(smp_wk[0], 1'b0, "R4 pull-up still held", 0);
      // R8: opposite request while busy is ignored
      cyc(3'b001, 3'b001);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         cyc('0, '0);
         if (smp_done[0]) break;
      end
      check(smp_frz[0], 1'b0, "R8 ignored mid-sequence request", 0);
      check(smp_sl[0], 1'b1, "R6 slew released last", 0);
      // R10: other banks untouched
      check(smp_frz[1], 1'b1, "R10 bank 1 still frozen", 1);
      check(smp_frz[2], 1'b1, "R10 bank 2 still frozen", 2);

      // R7: count busy cycles during freeze of bank 0
      cyc(3'b001, 3'b001);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         cyc('0, '0);
         if (smp_busy[0]) cnt++;
         if (smp_done[0]) break;
      end
      n_cmp++;
      if (cnt != G) begin
         n_bad++;
         $display("FAIL R7 freeze busy length: actual %0d expected %0d", cnt, G);
      end
      check(smp_frz[0], 1'b1, "R3 frozen after freeze", 0);

      // R10: simultaneous thaw on banks 1 and 2, then freeze bank 2 while bank 1 thawed
      cyc(3'b110, 3'b000);
      repeat (2 * G + 2) cyc('0, '0);
      cyc(3'b100, 3'b100);
      repeat (G + 2) cyc('0, '0);
      check(smp_frz[1], 1'b0, "R10 bank 1 thawed", 1);
      check(smp_frz[2], 1'b1, "R10 bank 2 refrozen", 2);

      // Back-to-back requests held continuously
      for (int i = 0; i < 60; i++) cyc('1, (i / 10) % 2 ? 3'b101 : 3'b010);

      // Random traffic
      for (int i = 0; i < 500; i++) cyc(NB'($urandom & $urandom), NB'($urandom));
      repeat (3 * G) cyc('0, '0);
      @(negedge clk);
      compare_all();

      finished = 1;
      summary();
      $finish;
   end

endmodule